// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter Engine

This block decides what happens to a received CAN frame based only on its identifier. A receive path hands it the identifier, whether it is an 11-bit standard or a 29-bit extended one, and whether it is a remote frame. The block then walks a programmable list of filter elements, one element per clock. There is one list for standard identifiers and a separate list for extended identifiers. The walk stops at the first enabled element that matches. If no element matches, the walk stops after the last element of the list.

Each element holds an action code, a match type and two identifier fields. The match type selects one of three comparisons: an inclusive range, either of two exact values, or a pattern with a care mask. The action code selects where the frame goes (FIFO 0, FIFO 1, a dedicated buffer, or rejection) and whether a priority flag is raised. Action 7 ignores the match type and requires an exact identifier. For extended identifiers, a global care mask is applied to the received identifier before most comparisons.

Elements are written through a single-cycle configuration port. Global settings are static inputs: the extended mask, the remote-frame rejection bits and the non-match policies. The result appears with a one-cycle done strobe and stays on the outputs until the next result.

Top module: `can_id_filter`

## Requirements
- R1: After reset, `busy` and `done` are 0 and the decision outputs are all 0. Every element resets to action 0 (disabled), so a request made before any configuration write ends with the non-match handling after a full walk of its list.
- R2: A request accepted at a rising edge (request `k`) produces exactly one `done` pulse lasting one cycle. If element j is the first enabled element that matches, `done` rises j+1 edges after `k` and `dec_elem` equals j. The lowest-indexed matching element always wins.
- R3: `dec_dest` is encoded as 0 = reject, 1 = FIFO 0, 2 = FIFO 1, 3 = dedicated buffer. The action codes map as follows:
  - 1 gives FIFO 0 and 2 gives FIFO 1.
  - 3 gives reject.
  - 4 gives reject with `dec_prio` = 1.
  - 5 gives FIFO 0 with priority, and 6 gives FIFO 1 with priority.
  - 7 gives buffer.
  `dec_matched` is 1 whenever an element decided the outcome.
- R4: Standard match types compare only the low 11 bits of the identifier and of ID1/ID2. The types are:
  - 0: inclusive range ID1..ID2.
  - 1: equality with ID1 or with ID2.
  - 2: equality under the care mask ID2, with ID1 as the pattern.
  - 3: the element never matches.
- R5: For extended requests, match types 0 to 2 compare the received identifier ANDed with `ext_gmask`. Match type 3 is an inclusive range ID1..ID2 on the unmasked identifier.
- R6: Action 7 matches only when the unmasked received identifier equals ID1 exactly, whatever the match type. The decision is then buffer, with `dec_bidx` = ID2[5:0] and no priority. For every other decision, `dec_bidx` is 0.
- R7: A remote frame is rejected after one cycle when the rejection bit for its format is set (`rtr_rej_std` or `rtr_rej_ext`). No element decides it, so `dec_matched` = 0 and `dec_elem` = 0. When the bit is clear, a remote frame is filtered like a data frame.
- R8: When no element matches, `dec_matched` = 0 and `dec_elem` = 0. The policy for the frame's format (`nomatch_std` or `nomatch_ext`) then sets the destination: 0 gives FIFO 0, 1 gives FIFO 1, 2 and 3 give reject. The result arrives after as many cycles as the list has elements.
- R9: A request made while `busy` is 1 has no effect. The decision outputs change only in the cycle where `done` is 1 and hold their values until the next `done`.
- R10: An element with action 0 is skipped even if its identifiers would match, and the walk continues with the next element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write one filter element this cycle |
| cfg_ext | input | 1 | Write target: 1 = extended list, 0 = standard list |
| cfg_idx | input | IDX_W (3) | Element index; indexes beyond the list are ignored |
| cfg_action | input | 3 | Action code of the element |
| cfg_mtype | input | 2 | Match type of the element |
| cfg_id1 | input | 29 | First identifier field |
| cfg_id2 | input | 29 | Second identifier field (range end, second ID, mask or buffer index) |
| ext_gmask | input | 29 | Global care mask for extended identifiers |
| rtr_rej_std | input | 1 | Reject all standard remote frames |
| rtr_rej_ext | input | 1 | Reject all extended remote frames |
| nomatch_std | input | 2 | Non-match policy for standard frames |
| nomatch_ext | input | 2 | Non-match policy for extended frames |
| req_valid | input | 1 | Start a filter run (ignored while busy) |
| req_ext | input | 1 | Identifier is extended |
| req_rtr | input | 1 | Frame is a remote frame |
| req_id | input | 29 | Received identifier (standard in bits 10:0) |
| busy | output | 1 | A walk of the list is in progress |
| done | output | 1 | One-cycle strobe: a new decision is on the outputs |
| dec_dest | output | 2 | Destination code |
| dec_prio | output | 1 | Priority flag |
| dec_matched | output | 1 | An element decided the outcome |
| dec_elem | output | IDX_W (3) | Index of the deciding element |
| dec_bidx | output | 6 | Dedicated buffer index |

## Verification
The hardest case to reach is one where several elements could claim the same identifier. Showing that the earliest one wins requires identifiers that a disabled element, a match-type-3 standard element, or the extended raw-range element would otherwise capture first. The stimulus programs one fixed list in which these overlaps are deliberate. It then times each request from acceptance to strobe, so the index of the deciding element and the scan length are both checked. The ignored-while-busy case is reached by issuing a second request in the cycle right after the first one is accepted, while a full non-match walk is still running.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;

    localparam int STD_ID_W = 11;
    localparam int EXT_ID_W = 29;
    localparam int BIDX_W   = 6;

    typedef struct packed {
        logic [2:0]          action;
        logic [1:0]          mtype;
        logic [EXT_ID_W-1:0] id1;
        logic [EXT_ID_W-1:0] id2;
    } flt_elem_t;

    typedef enum logic [1:0] {
        DEST_REJECT = 2'd0,
        DEST_FIFO0  = 2'd1,
        DEST_FIFO1  = 2'd2,
        DEST_BUF    = 2'd3
    } dest_t;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_SCAN = 1'b1
    } phase_t;

endpackage

// File: rtl/can_flt_store.sv
module can_flt_store
    import can_flt_pkg::*;
#(
    parameter int STD_ELEMS = 8,
    parameter int EXT_ELEMS = 4,
    parameter int IDX_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_ext,
    input  logic [IDX_W-1:0] wr_idx,
    input  flt_elem_t        wr_elem,
    input  logic             rd_ext,
    input  logic [IDX_W-1:0] rd_idx,
    output flt_elem_t        rd_elem
);

    flt_elem_t std_q [STD_ELEMS];
    flt_elem_t std_d [STD_ELEMS];
    flt_elem_t ext_q [EXT_ELEMS];
    flt_elem_t ext_d [EXT_ELEMS];

    for (genvar i = 0; i < STD_ELEMS; i++) begin : g_std
        always_comb begin
            std_d[i] = std_q[i];
            if (wr_en && !wr_ext && wr_idx == IDX_W'(i)) begin
                std_d[i] = wr_elem;
            end
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) std_q[i] <= '0;
            else        std_q[i] <= std_d[i];
        end
    end

    for (genvar i = 0; i < EXT_ELEMS; i++) begin : g_ext
        always_comb begin
            ext_d[i] = ext_q[i];
            if (wr_en && wr_ext && wr_idx == IDX_W'(i)) begin
                ext_d[i] = wr_elem;
            end
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ext_q[i] <= '0;
            else        ext_q[i] <= ext_d[i];
        end
    end

    always_comb begin
        rd_elem = '0;
        for (int i = 0; i < STD_ELEMS; i++) begin
            if (!rd_ext && rd_idx == IDX_W'(i)) rd_elem = std_q[i];
        end
        for (int i = 0; i < EXT_ELEMS; i++) begin
            if (rd_ext && rd_idx == IDX_W'(i)) rd_elem = ext_q[i];
        end
    end

endmodule

// File: rtl/can_flt_match.sv
module can_flt_match
    import can_flt_pkg::*;
(
    input  flt_elem_t            elem,
    input  logic [EXT_ID_W-1:0]  id,
    input  logic                 is_ext,
    input  logic [EXT_ID_W-1:0]  gmask,
    output logic                 hit,
    output dest_t                dest,
    output logic                 prio,
    output logic [BIDX_W-1:0]    bidx
);

    localparam int PAD_W = EXT_ID_W - STD_ID_W;

    logic [EXT_ID_W-1:0] raw_id;
    logic [EXT_ID_W-1:0] cmp_id;
    logic [EXT_ID_W-1:0] e1;
    logic [EXT_ID_W-1:0] e2;
    logic                in_range;
    logic                is_dual;
    logic                is_mask;

    always_comb begin
        raw_id = is_ext ? id : {{PAD_W{1'b0}}, id[STD_ID_W-1:0]};
        e1     = is_ext ? elem.id1 : {{PAD_W{1'b0}}, elem.id1[STD_ID_W-1:0]};
        e2     = is_ext ? elem.id2 : {{PAD_W{1'b0}}, elem.id2[STD_ID_W-1:0]};
        if (is_ext && elem.mtype != 2'd3) cmp_id = id & gmask;
        else                              cmp_id = raw_id;

        in_range = (e1 <= cmp_id) && (cmp_id <= e2);
        is_dual  = (cmp_id == e1) || (cmp_id == e2);
        is_mask  = ((cmp_id ^ e1) & e2) == '0;

        hit = 1'b0;
        if (elem.action == 3'd7) begin
            hit = (raw_id == e1);
        end else if (elem.action != 3'd0) begin
            case (elem.mtype)
                2'd0:    hit = in_range;
                2'd1:    hit = is_dual;
                2'd2:    hit = is_mask;
                default: hit = is_ext && in_range;
            endcase
        end

        prio = 1'b0;
        bidx = '0;
        case (elem.action)
            3'd1:    dest = DEST_FIFO0;
            3'd2:    dest = DEST_FIFO1;
            3'd4:    begin dest = DEST_REJECT; prio = 1'b1; end
            3'd5:    begin dest = DEST_FIFO0;  prio = 1'b1; end
            3'd6:    begin dest = DEST_FIFO1;  prio = 1'b1; end
            3'd7:    begin dest = DEST_BUF; bidx = elem.id2[BIDX_W-1:0]; end
            default: dest = DEST_REJECT;
        endcase
    end

    // R10
    disabled_nohit_chk: assert final (!(elem.action == 3'd0 && hit));

endmodule

// File: rtl/can_id_filter.sv
module can_id_filter
    import can_flt_pkg::*;
#(
    parameter int STD_ELEMS = 8,
    parameter int EXT_ELEMS = 4,
    parameter int IDX_W     = $clog2((STD_ELEMS > EXT_ELEMS) ? STD_ELEMS : EXT_ELEMS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_ext,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [2:0]        cfg_action,
    input  logic [1:0]        cfg_mtype,
    input  logic [28:0]       cfg_id1,
    input  logic [28:0]       cfg_id2,
    input  logic [28:0]       ext_gmask,
    input  logic              rtr_rej_std,
    input  logic              rtr_rej_ext,
    input  logic [1:0]        nomatch_std,
    input  logic [1:0]        nomatch_ext,
    input  logic              req_valid,
    input  logic              req_ext,
    input  logic              req_rtr,
    input  logic [28:0]       req_id,
    output logic              busy,
    output logic              done,
    output logic [1:0]        dec_dest,
    output logic              dec_prio,
    output logic              dec_matched,
    output logic [IDX_W-1:0]  dec_elem,
    output logic [5:0]        dec_bidx
);

    localparam logic [IDX_W-1:0] STD_LAST = IDX_W'(STD_ELEMS - 1);
    localparam logic [IDX_W-1:0] EXT_LAST = IDX_W'(EXT_ELEMS - 1);

    typedef struct packed {
        phase_t              phase;
        logic [IDX_W-1:0]    idx;
        logic [EXT_ID_W-1:0] id;
        logic                ext;
        logic                drop;
        logic                done;
        dest_t               dest;
        logic                prio;
        logic                matched;
        logic [IDX_W-1:0]    elem;
        logic [BIDX_W-1:0]   bidx;
    } fsm_t;

    fsm_t st_q, st_d;

    flt_elem_t         cur_elem;
    flt_elem_t         wr_elem;
    logic              m_hit;
    dest_t             m_dest;
    logic              m_prio;
    logic [BIDX_W-1:0] m_bidx;
    logic [1:0]        nm_pol;
    dest_t             nm_dest;

    assign wr_elem = '{action: cfg_action, mtype: cfg_mtype, id1: cfg_id1, id2: cfg_id2};

    can_flt_store #(
        .STD_ELEMS (STD_ELEMS),
        .EXT_ELEMS (EXT_ELEMS),
        .IDX_W     (IDX_W)
    ) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_ext  (cfg_ext),
        .wr_idx  (cfg_idx),
        .wr_elem (wr_elem),
        .rd_ext  (st_q.ext),
        .rd_idx  (st_q.idx),
        .rd_elem (cur_elem)
    );

    can_flt_match match_i (
        .elem   (cur_elem),
        .id     (st_q.id),
        .is_ext (st_q.ext),
        .gmask  (ext_gmask),
        .hit    (m_hit),
        .dest   (m_dest),
        .prio   (m_prio),
        .bidx   (m_bidx)
    );

    always_comb begin
        nm_pol = st_q.ext ? nomatch_ext : nomatch_std;
        case (nm_pol)
            2'd0:    nm_dest = DEST_FIFO0;
            2'd1:    nm_dest = DEST_FIFO1;
            default: nm_dest = DEST_REJECT;
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.phase = PH_SCAN;
                    st_d.idx   = '0;
                    st_d.id    = req_id;
                    st_d.ext   = req_ext;
                    st_d.drop  = req_rtr && (req_ext ? rtr_rej_ext : rtr_rej_std);
                end
            end
            default: begin
                if (st_q.drop) begin
                    st_d.phase   = PH_IDLE;
                    st_d.done    = 1'b1;
                    st_d.dest    = DEST_REJECT;
                    st_d.prio    = 1'b0;
                    st_d.matched = 1'b0;
                    st_d.elem    = '0;
                    st_d.bidx    = '0;
                end else if (m_hit) begin
                    st_d.phase   = PH_IDLE;
                    st_d.done    = 1'b1;
                    st_d.dest    = m_dest;
                    st_d.prio    = m_prio;
                    st_d.matched = 1'b1;
                    st_d.elem    = st_q.idx;
                    st_d.bidx    = m_bidx;
                end else if (st_q.idx == (st_q.ext ? EXT_LAST : STD_LAST)) begin
                    st_d.phase   = PH_IDLE;
                    st_d.done    = 1'b1;
                    st_d.dest    = nm_dest;
                    st_d.prio    = 1'b0;
                    st_d.matched = 1'b0;
                    st_d.elem    = '0;
                    st_d.bidx    = '0;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, dest: DEST_REJECT, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy        = (st_q.phase == PH_SCAN);
    assign done        = st_q.done;
    assign dec_dest    = st_q.dest;
    assign dec_prio    = st_q.prio;
    assign dec_matched = st_q.matched;
    assign dec_elem    = st_q.elem;
    assign dec_bidx    = st_q.bidx;

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> (busy || done));

    // R9
    dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dec_dest) |-> done);

    // R7
    rtr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && st_q.drop) |-> (dec_dest == DEST_REJECT && !dec_matched));

    // R6
    buf_noprio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dec_dest == DEST_BUF) |-> (!dec_prio && dec_matched));

endmodule

// File: tb/can_id_filter_tb.sv
`timescale 1ns/1ps
module can_id_filter_tb_top;

    localparam int IDX_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic             cfg_ext = 1'b0;
    logic [IDX_W-1:0] cfg_idx = '0;
    logic [2:0]       cfg_action = '0;
    logic [1:0]       cfg_mtype = '0;
    logic [28:0]      cfg_id1 = '0;
    logic [28:0]      cfg_id2 = '0;
    logic [28:0]      ext_gmask = '1;
    logic             rtr_rej_std = 1'b0;
    logic             rtr_rej_ext = 1'b0;
    logic [1:0]       nomatch_std = 2'd0;
    logic [1:0]       nomatch_ext = 2'd0;
    logic             req_valid = 1'b0;
    logic             req_ext = 1'b0;
    logic             req_rtr = 1'b0;
    logic [28:0]      req_id = '0;
    logic             busy, done, dec_prio, dec_matched;
    logic [1:0]       dec_dest;
    logic [IDX_W-1:0] dec_elem;
    logic [5:0]       dec_bidx;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    can_id_filter dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_ext(cfg_ext), .cfg_idx(cfg_idx),
        .cfg_action(cfg_action), .cfg_mtype(cfg_mtype),
        .cfg_id1(cfg_id1), .cfg_id2(cfg_id2),
        .ext_gmask(ext_gmask), .rtr_rej_std(rtr_rej_std), .rtr_rej_ext(rtr_rej_ext),
        .nomatch_std(nomatch_std), .nomatch_ext(nomatch_ext),
        .req_valid(req_valid), .req_ext(req_ext), .req_rtr(req_rtr), .req_id(req_id),
        .busy(busy), .done(done), .dec_dest(dec_dest), .dec_prio(dec_prio),
        .dec_matched(dec_matched), .dec_elem(dec_elem), .dec_bidx(dec_bidx)
    );

    typedef struct packed {
        logic        ext;
        logic        rtr;
        logic [28:0] id;
        logic [1:0]  dest;
        logic        prio;
        logic        matched;
        logic [2:0]  elem;
        logic [5:0]  bidx;
        logic [4:0]  lat;
    } vec_t;

    // dest: 0 reject, 1 FIFO0, 2 FIFO1, 3 buffer
    localparam vec_t VECS [17] = '{
        '{1'b0, 1'b0, 29'h100,      2'd1, 1'b0, 1'b1, 3'd1, 6'd0,  5'd2}, // R10 R4
        '{1'b0, 1'b0, 29'h10F,      2'd1, 1'b0, 1'b1, 3'd1, 6'd0,  5'd2}, // R4
        '{1'b0, 1'b0, 29'h110,      2'd2, 1'b0, 1'b0, 3'd0, 6'd0,  5'd8}, // R8
        '{1'b0, 1'b0, 29'h255,      2'd2, 1'b0, 1'b1, 3'd2, 6'd0,  5'd3}, // R4 R3
        '{1'b0, 1'b0, 29'h200,      2'd2, 1'b0, 1'b1, 3'd2, 6'd0,  5'd3}, // R4
        '{1'b0, 1'b0, 29'h305,      2'd1, 1'b1, 1'b1, 3'd3, 6'd0,  5'd4}, // R2 R3
        '{1'b0, 1'b0, 29'h123,      2'd3, 1'b0, 1'b1, 3'd4, 6'd5,  5'd5}, // R6
        '{1'b0, 1'b0, 29'h0F0,      2'd0, 1'b0, 1'b1, 3'd5, 6'd0,  5'd6}, // R3
        '{1'b0, 1'b0, 29'h400,      2'd0, 1'b1, 1'b1, 3'd7, 6'd0,  5'd8}, // R4 R3
        '{1'b0, 1'b1, 29'h105,      2'd0, 1'b0, 1'b0, 3'd0, 6'd0,  5'd1}, // R7
        '{1'b1, 1'b0, 29'h12345678, 2'd2, 1'b1, 1'b1, 3'd0, 6'd0,  5'd1}, // R5 R3
        '{1'b1, 1'b1, 29'h12345678, 2'd2, 1'b1, 1'b1, 3'd0, 6'd0,  5'd1}, // R7
        '{1'b1, 1'b0, 29'h00ABC001, 2'd2, 1'b0, 1'b1, 3'd1, 6'd0,  5'd2}, // R5 R2
        '{1'b1, 1'b0, 29'h00ABC003, 2'd1, 1'b0, 1'b1, 3'd2, 6'd0,  5'd3}, // R5
        '{1'b1, 1'b0, 29'h1ABCDEF1, 2'd3, 1'b0, 1'b1, 3'd3, 6'd42, 5'd4}, // R6
        '{1'b1, 1'b0, 29'h1ABCDEF0, 2'd0, 1'b0, 1'b0, 3'd0, 6'd0,  5'd4}, // R6 R8
        '{1'b0, 1'b0, 29'h1FFFF105, 2'd1, 1'b0, 1'b1, 3'd1, 6'd0,  5'd2}  // R4
    };

    task automatic chk(input string req, input logic ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic ext, input int idx, input logic [2:0] act,
                             input logic [1:0] mt, input logic [28:0] i1, input logic [28:0] i2);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ext = ext; cfg_idx = IDX_W'(idx);
        cfg_action = act; cfg_mtype = mt; cfg_id1 = i1; cfg_id2 = i2;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_req(input logic ext, input logic rtr, input logic [28:0] id, output int lat);
        @(negedge clk);
        req_valid = 1'b1; req_ext = ext; req_rtr = rtr; req_id = id;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int lat;
        int dones;
        repeat (3) @(negedge clk);
        chk("R1 busy", busy == 1'b0, busy, 0);
        chk("R1 done", done == 1'b0, done, 0);
        chk("R1 dec", {dec_dest, dec_prio, dec_matched, dec_elem, dec_bidx} == '0,
            {dec_dest, dec_prio, dec_matched, dec_elem, dec_bidx}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after release", busy == 1'b0, busy, 0);

        // R1: empty list, standard non-match policy FIFO0, full 8-element walk
        run_req(1'b0, 1'b0, 29'h123, lat);
        chk("R1 empty lat", lat == 8, lat, 8);
        chk("R1 empty dest", dec_dest == 2'd1, dec_dest, 1);
        chk("R1 empty matched", dec_matched == 1'b0, dec_matched, 0);

        nomatch_std = 2'd1;
        nomatch_ext = 2'd2;
        rtr_rej_std = 1'b1;
        rtr_rej_ext = 1'b0;
        ext_gmask   = 29'h1FFFFFF0;

        cfg_write(1'b0, 0, 3'd0, 2'd1, 29'h100, 29'h100);
        cfg_write(1'b0, 1, 3'd1, 2'd0, 29'h100, 29'h10F);
        cfg_write(1'b0, 2, 3'd2, 2'd1, 29'h200, 29'h255);
        cfg_write(1'b0, 3, 3'd5, 2'd2, 29'h300, 29'h7F0);
        cfg_write(1'b0, 4, 3'd7, 2'd3, 29'h123, 29'h005);
        cfg_write(1'b0, 5, 3'd3, 2'd0, 29'h000, 29'h0FF);
        cfg_write(1'b0, 6, 3'd1, 2'd3, 29'h400, 29'h4FF);
        cfg_write(1'b0, 7, 3'd4, 2'd1, 29'h400, 29'h305);
        cfg_write(1'b1, 0, 3'd6, 2'd2, 29'h12345670, 29'h1FFFFFFF);
        cfg_write(1'b1, 1, 3'd2, 2'd3, 29'h00ABC001, 29'h00ABC002);
        cfg_write(1'b1, 2, 3'd1, 2'd0, 29'h00ABC000, 29'h00ABC000);
        cfg_write(1'b1, 3, 3'd7, 2'd0, 29'h1ABCDEF1, 29'h0000002A);
        // out-of-range index on the extended list: ignored
        cfg_write(1'b1, 5, 3'd1, 2'd0, 29'h0, 29'h1FFFFFFF);

        for (int v = 0; v < 17; v++) begin
            run_req(VECS[v].ext, VECS[v].rtr, VECS[v].id, lat);
            chk($sformatf("R2 vec%0d latency", v), lat == int'(VECS[v].lat), lat, VECS[v].lat);
            chk($sformatf("R3 vec%0d dest", v), dec_dest == VECS[v].dest, dec_dest, VECS[v].dest);
            chk($sformatf("R3 vec%0d prio", v), dec_prio == VECS[v].prio, dec_prio, VECS[v].prio);
            chk($sformatf("R8 vec%0d matched", v), dec_matched == VECS[v].matched, dec_matched, VECS[v].matched);
            chk($sformatf("R2 vec%0d elem", v), dec_elem == VECS[v].elem, dec_elem, VECS[v].elem);
            chk($sformatf("R6 vec%0d bidx", v), dec_bidx == VECS[v].bidx, dec_bidx, VECS[v].bidx);
            @(negedge clk);
            chk($sformatf("R2 vec%0d done one cycle", v), done == 1'b0, done, 0);
        end

        // R9: second request during a walk is ignored
        @(negedge clk);
        req_valid = 1'b1; req_ext = 1'b0; req_rtr = 1'b0; req_id = 29'h600;
        @(negedge clk);
        req_id = 29'h305;
        @(negedge clk);
        req_valid = 1'b0;
        dones = 0;
        for (int c = 0; c < 20; c++) begin
            if (done) dones++;
            @(negedge clk);
        end
        chk("R9 single done", dones == 1, dones, 1);
        chk("R9 first request result dest", dec_dest == 2'd2, dec_dest, 2);
        chk("R9 first request unmatched", dec_matched == 1'b0, dec_matched, 0);
        chk("R9 held prio", dec_prio == 1'b0, dec_prio, 0);

        // R8: non-match policy value 3 also rejects; R9: outputs held afterwards
        nomatch_std = 2'd3;
        run_req(1'b0, 1'b0, 29'h7AA, lat);
        chk("R8 policy3 dest", dec_dest == 2'd0, dec_dest, 0);
        nomatch_std = 2'd0;
        repeat (10) @(negedge clk);
        chk("R9 held dest", dec_dest == 2'd0, dec_dest, 0);

        // R7: clearing the standard rejection bit lets a remote frame through filtering
        rtr_rej_std = 1'b0;
        run_req(1'b0, 1'b1, 29'h105, lat);
        chk("R7 rtr allowed dest", dec_dest == 2'd1, dec_dest, 1);
        chk("R7 rtr allowed elem", dec_elem == 3'd1, dec_elem, 1);

        // R5: extended rtr rejection bit applies only to extended frames
        rtr_rej_ext = 1'b1;
        run_req(1'b1, 1'b1, 29'h12345678, lat);
        chk("R7 ext rtr reject lat", lat == 1, lat, 1);
        chk("R7 ext rtr reject dest", dec_dest == 2'd0, dec_dest, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule